// File: doc/BRIEF.md
# Parallel Step Assembler with Jump Flush

This block is the control and assembly stage of an on-the-fly instruction decompressor for a wide reconfigurable array. Program memory is read as 160-bit fetch words, each carrying eight 20-bit codewords. A direct codeword names a unit group with its upper five bits and carries that group's 15 configuration bits in its lower fifteen. The assembler copies each direct payload into the group's fixed place in a 474-bit step word. It merges results that separate dictionary decoders return on a result port. It leaves every group that nobody wrote at zero, which is the no-op setting. Once the step is complete it offers it to the array under a valid/ready handshake.

A step may span several fetch words. It ends with a reserved marker codeword. One registered fetch stage sits ahead of the assembly, so the next fetch word is prefetched while the current one is decoded. Fetching stops while a finished step waits for the array. A jump request flushes everything that is in flight, including the partly built step and any prefetched word. It then restarts fetching at the address that came with the jump.

Top module: `step_asm`

## Requirements
- R1: While reset is high and in the first cycle after it, stepValid is 0, stepData is all zero and fetchAddr is 0.
- R2: The block requests a word (fetchReq high) whenever its single fetch buffer is empty or being drained in that cycle. A word transfers on a cycle with fetchReq and fetchValid both high. fetchAddr then advances by one.
- R3: Codeword lane k sits at fetch bits [20k+19:20k]. Its group id is bits [19:15] and its payload is bits [14:0]. A direct codeword with group id g in 0..30 places its payload at stepData[15g+14:15g].
- R4: A codeword with group id 31 and zero payload ends the step. Lanes after it in the same word are ignored. A group-31 codeword with a nonzero payload writes nothing.
- R5: A step may span several fetch words. Every group not written during the step reads as zero in the presented step, including groups written by the previous step.
- R6: With the fetch buffer empty and the array ready, a single-word step is presented (stepValid high) after the third clock edge that follows the transfer of its word.
- R7: Dictionary results (dictValid, dictGroup, dictData) are merged while the step is being assembled, including the cycle right after the marker is decoded. Group 31 maps to stepData[473:465], which holds the low 9 bits of dictData. While a finished step is being presented, results are ignored.
- R8: If a group is written more than once within a step, the later write wins and stepDupErr is 1 while that step is presented. Lanes are ordered by index, and a dictionary result is applied after the lanes of the same cycle. stepDupErr is 0 for a step without repeats.
- R9: stepValid stays high and stepData stays stable until stepReady is seen. When one word is already buffered, fetchReq stays low and fetchAddr does not move.
- R10: A cycle with jumpValid high discards the partial step and the buffered word. In the next cycle fetchAddr equals jumpAddr and stepValid is 0, and no word is taken in the jump cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetchReq | output | 1 | Request for the word at fetchAddr |
| fetchAddr | output | 16 | Program word address |
| fetchValid | input | 1 | Memory has fetchData for fetchAddr |
| fetchData | input | 160 | Eight codewords, lane 0 in the low bits |
| dictValid | input | 1 | A dictionary decoder returns a group result |
| dictGroup | input | 5 | Group the result belongs to |
| dictData | input | 15 | Decoded group bits |
| jumpValid | input | 1 | Flush and restart at jumpAddr |
| jumpAddr | input | 16 | Branch target word address |
| stepValid | output | 1 | A complete step is on stepData |
| stepReady | input | 1 | The array takes the step |
| stepData | output | 474 | Assembled step word |
| stepDupErr | output | 1 | The presented step had a group written twice |

## Verification
The bench places garbage codewords after an end marker and a reserved group-31 codeword with a nonzero payload. A design that scans past the marker, or that treats every group-31 word as a terminator, shows stray bits or truncated steps. Each multi-word step deliberately leaves out groups the previous step used, which exposes a design that never clears its step register. Dictionary results are driven both in the cycle after the marker, where they must land, and while a step is held, where they must not change it. Jumps are issued once mid-step with a word prefetched and once while a step waits. A design that keeps the buffered word or the partial step shows groups from the abandoned stream in the next step.

// File: rtl/step_asm_pkg.sv
package step_asm_pkg;

  localparam int DEF_ADDR_W  = 16;
  localparam int DEF_FETCH_W = 160;
  localparam int DEF_GID_W   = 5;
  localparam int DEF_GRP_W   = 15;
  localparam int DEF_STEP_W  = 474;

  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_DRAIN = 2'd1,
    ST_HOLD  = 2'd2
  } asmState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadWord;   // capture fetchData into the fetch buffer
    logic consume;    // decode the buffered word into the step
    logic dictEn;     // dictionary results may be merged
    logic clearStep;  // start a fresh, all-zero step
  } asmStrobe_t;

endpackage

// File: rtl/step_asm_ctrl.sv
module step_asm_ctrl
  import step_asm_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetchValid,
  input  logic              jumpValid,
  input  logic [ADDR_W-1:0] jumpAddr,
  input  logic              stepReady,
  input  logic              wordHasMarker,
  output logic              fetchReq,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic              stepValid,
  output asmStrobe_t        strobe
);

  asmState_t stateQ;
  logic      wordValidQ;

  always_comb begin
    strobe.consume   = !jumpValid && (stateQ == ST_FETCH) && wordValidQ;
    fetchReq         = !jumpValid && (!wordValidQ || strobe.consume);
    strobe.loadWord  = fetchReq && fetchValid;
    strobe.dictEn    = !jumpValid && ((stateQ == ST_FETCH) || (stateQ == ST_DRAIN));
    strobe.clearStep = jumpValid || ((stateQ == ST_HOLD) && stepReady);
  end

  assign stepValid = (stateQ == ST_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ     <= ST_FETCH;
      wordValidQ <= 1'b0;
      fetchAddr  <= '0;
    end else if (jumpValid) begin
      stateQ     <= ST_FETCH;
      wordValidQ <= 1'b0;
      fetchAddr  <= jumpAddr;
    end else begin
      if (strobe.loadWord) begin
        fetchAddr  <= fetchAddr + 1'b1;
        wordValidQ <= 1'b1;
      end else if (strobe.consume) begin
        wordValidQ <= 1'b0;
      end
      unique case (stateQ)
        ST_FETCH: if (strobe.consume && wordHasMarker) stateQ <= ST_DRAIN;
        ST_DRAIN: stateQ <= ST_HOLD;
        ST_HOLD:  if (stepReady) stateQ <= ST_FETCH;
        default:  stateQ <= ST_FETCH;
      endcase
    end
  end

endmodule

// File: rtl/step_asm_dp.sv
module step_asm_dp
  import step_asm_pkg::*;
#(
  parameter int FETCH_W = DEF_FETCH_W,
  parameter int GID_W   = DEF_GID_W,
  parameter int GRP_W   = DEF_GRP_W,
  parameter int STEP_W  = DEF_STEP_W
) (
  input  logic               clk,
  input  logic               rst,
  input  asmStrobe_t         strobe,
  input  logic [FETCH_W-1:0] fetchData,
  input  logic               dictValid,
  input  logic [GID_W-1:0]   dictGroup,
  input  logic [GRP_W-1:0]   dictData,
  output logic               wordHasMarker,
  output logic [STEP_W-1:0]  stepData,
  output logic               dupFlag
);

  localparam int CW_W    = GID_W + GRP_W;
  localparam int NLANES  = FETCH_W / CW_W;
  localparam int NSLOT   = (STEP_W + GRP_W - 1) / GRP_W;
  localparam int LAST_W  = STEP_W - (NSLOT - 1) * GRP_W;
  localparam logic [GID_W-1:0] MARK_ID = '1;

  logic [FETCH_W-1:0] wordQ;
  logic [GID_W-1:0]   laneGid [NLANES];
  logic [GRP_W-1:0]   lanePay [NLANES];
  logic               laneWr  [NLANES];
  logic [NSLOT-1:0]   slotDup;

  always_ff @(posedge clk) begin
    if (rst)                  wordQ <= '0;
    else if (strobe.loadWord) wordQ <= fetchData;
  end

  // lane split and end-marker scan: lanes after the first marker are dead
  always_comb begin
    logic live;
    logic isMark;
    live          = 1'b1;
    wordHasMarker = 1'b0;
    for (int l = 0; l < NLANES; l++) begin
      laneGid[l] = wordQ[l*CW_W + GRP_W +: GID_W];
      lanePay[l] = wordQ[l*CW_W +: GRP_W];
      isMark     = (laneGid[l] == MARK_ID) && (lanePay[l] == '0);
      laneWr[l]  = strobe.consume && live && (laneGid[l] != MARK_ID);
      if (live && isMark) wordHasMarker = 1'b1;
      live = live && !isMark;
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : gSlot
    localparam int W = (g == NSLOT - 1) ? LAST_W : GRP_W;
    logic [W-1:0] slotQ;
    logic [W-1:0] slotD;
    logic         seenQ;
    logic         hit;
    logic         multi;

    always_comb begin
      hit   = 1'b0;
      multi = 1'b0;
      slotD = slotQ;
      for (int l = 0; l < NLANES; l++) begin
        if (laneWr[l] && (laneGid[l] == GID_W'(g))) begin
          multi = multi || hit;
          hit   = 1'b1;
          slotD = lanePay[l][W-1:0];
        end
      end
      if (strobe.dictEn && dictValid && (dictGroup == GID_W'(g))) begin
        multi = multi || hit;
        hit   = 1'b1;
        slotD = dictData[W-1:0];
      end
    end

    assign slotDup[g] = multi || (hit && seenQ);

    always_ff @(posedge clk) begin
      if (rst || strobe.clearStep) begin
        slotQ <= '0;
        seenQ <= 1'b0;
      end else if (hit) begin
        slotQ <= slotD;
        seenQ <= 1'b1;
      end
    end

    assign stepData[g*GRP_W +: W] = slotQ;
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.clearStep) dupFlag <= 1'b0;
    else if (|slotDup)           dupFlag <= 1'b1;
  end

endmodule

// File: rtl/step_asm.sv
module step_asm
  import step_asm_pkg::*;
#(
  parameter int ADDR_W  = DEF_ADDR_W,
  parameter int FETCH_W = DEF_FETCH_W,
  parameter int GID_W   = DEF_GID_W,
  parameter int GRP_W   = DEF_GRP_W,
  parameter int STEP_W  = DEF_STEP_W
) (
  input  logic               clk,
  input  logic               rst,
  output logic               fetchReq,
  output logic [ADDR_W-1:0]  fetchAddr,
  input  logic               fetchValid,
  input  logic [FETCH_W-1:0] fetchData,
  input  logic               dictValid,
  input  logic [GID_W-1:0]   dictGroup,
  input  logic [GRP_W-1:0]   dictData,
  input  logic               jumpValid,
  input  logic [ADDR_W-1:0]  jumpAddr,
  output logic               stepValid,
  input  logic               stepReady,
  output logic [STEP_W-1:0]  stepData,
  output logic               stepDupErr
);

  asmStrobe_t strobe;
  logic       wordHasMarker;
  logic       dupFlag;

  step_asm_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst(rst), .fetchValid(fetchValid), .jumpValid(jumpValid),
    .jumpAddr(jumpAddr), .stepReady(stepReady), .wordHasMarker(wordHasMarker),
    .fetchReq(fetchReq), .fetchAddr(fetchAddr), .stepValid(stepValid),
    .strobe(strobe)
  );

  step_asm_dp #(
    .FETCH_W(FETCH_W), .GID_W(GID_W), .GRP_W(GRP_W), .STEP_W(STEP_W)
  ) dp_i (
    .clk(clk), .rst(rst), .strobe(strobe), .fetchData(fetchData),
    .dictValid(dictValid), .dictGroup(dictGroup), .dictData(dictData),
    .wordHasMarker(wordHasMarker), .stepData(stepData), .dupFlag(dupFlag)
  );

  assign stepDupErr = dupFlag && stepValid;

endmodule

// File: rtl/step_asm_chk.sv
module step_asm_chk #(
  parameter int ADDR_W = 16,
  parameter int STEP_W = 474
) (
  input logic              clk,
  input logic              rst,
  input logic              fetchReq,
  input logic              fetchValid,
  input logic [ADDR_W-1:0] fetchAddr,
  input logic              jumpValid,
  input logic [ADDR_W-1:0] jumpAddr,
  input logic              stepValid,
  input logic              stepReady,
  input logic [STEP_W-1:0] stepData
);

  // R2: each transfer advances the address by one
  assert_addr_advance_R2: assert property (@(posedge clk) disable iff (rst)
    fetchReq && fetchValid && !jumpValid |=> fetchAddr == ADDR_W'($past(fetchAddr) + 1'b1));

  // R9: presented step held until taken
  assert_valid_held_R9: assert property (@(posedge clk) disable iff (rst)
    stepValid && !stepReady && !jumpValid |=> stepValid);

  assert_data_stable_R9: assert property (@(posedge clk) disable iff (rst)
    stepValid && !stepReady && !jumpValid |=> $stable(stepData));

  // R10: jump redirects fetch and drops the step
  assert_jump_redirect_R10: assert property (@(posedge clk) disable iff (rst)
    jumpValid |=> (fetchAddr == $past(jumpAddr)) && !stepValid);

  assert_no_fetch_on_jump_R10: assert property (@(posedge clk) disable iff (rst)
    jumpValid |-> !fetchReq);

endmodule

bind step_asm step_asm_chk #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) chk_i (
  .clk(clk), .rst(rst), .fetchReq(fetchReq), .fetchValid(fetchValid),
  .fetchAddr(fetchAddr), .jumpValid(jumpValid), .jumpAddr(jumpAddr),
  .stepValid(stepValid), .stepReady(stepReady), .stepData(stepData)
);

// File: tb/step_asm_tb_top.sv
module step_asm_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int STEP_W = 474;

  logic         clk = 1'b0;
  logic         rst;
  logic         fetchReq;
  logic [15:0]  fetchAddr;
  logic         fetchValid;
  logic [159:0] fetchData;
  logic         dictValid;
  logic [4:0]   dictGroup;
  logic [14:0]  dictData;
  logic         jumpValid;
  logic [15:0]  jumpAddr;
  logic         stepValid;
  logic         stepReady;
  logic [STEP_W-1:0] stepData;
  logic         stepDupErr;

  logic [159:0] mem [64];
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign fetchData = mem[fetchAddr[5:0]];

  step_asm dut_i (
    .clk(clk), .rst(rst), .fetchReq(fetchReq), .fetchAddr(fetchAddr),
    .fetchValid(fetchValid), .fetchData(fetchData), .dictValid(dictValid),
    .dictGroup(dictGroup), .dictData(dictData), .jumpValid(jumpValid),
    .jumpAddr(jumpAddr), .stepValid(stepValid), .stepReady(stepReady),
    .stepData(stepData), .stepDupErr(stepDupErr)
  );

  function automatic logic [19:0] cw(input int gid, input int pay);
    return {gid[4:0], pay[14:0]};
  endfunction

  localparam logic [19:0] MARK = 20'hF8000;

  function automatic logic [159:0] word8(input logic [19:0] c0, c1, c2, c3, c4, c5, c6, c7);
    return {c7, c6, c5, c4, c3, c2, c1, c0};
  endfunction

  function automatic logic [STEP_W-1:0] sl(input int g, input int val);
    logic [STEP_W-1:0] v;
    v = '0;
    v[14:0] = val[14:0];
    return v << (g * 15);
  endfunction

  task automatic chk1(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chkStep(input string req, input logic [STEP_W-1:0] exp);
    checks++;
    if (stepData !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, stepData, exp);
    end
  endtask

  task automatic waitStep(input string req);
    int n = 0;
    while (!stepValid && n < 50) begin
      @(posedge clk); @(negedge clk); n++;
    end
    chk1(req, 64'(stepValid), 64'd1);
  endtask

  task automatic acceptStep();
    stepReady = 1'b1;
    @(posedge clk); @(negedge clk);
    stepReady = 1'b0;
  endtask

  task automatic testReset();
    chk1("R1 stepValid", 64'(stepValid), 64'd0);
    chk1("R1 fetchAddr", 64'(fetchAddr), 64'd0);
    chk1("R1 stepData zero", 64'(stepData == '0), 64'd1);
    chk1("R2 fetchReq with empty buffer", 64'(fetchReq), 64'd1);
  endtask

  task automatic testLatencyAndMarker();
    int n = 0;
    fetchValid = 1'b1;
    while (!stepValid && n < 20) begin
      @(posedge clk); @(negedge clk); n++;
    end
    chk1("R6 edges to present", 64'(n), 64'd3);
    chkStep("R3 R4 direct slots, lanes after marker ignored",
            sl(0, 'h1111) | sl(5, 'h2AAA) | sl(30, 'h7FFF));
    chk1("R8 no repeat flag", 64'(stepDupErr), 64'd0);
  endtask

  task automatic testHoldAndDictIgnored();
    logic [STEP_W-1:0] snap;
    snap = stepData;
    dictValid = 1'b1; dictGroup = 5'd12; dictData = 15'h4321;
    repeat (3) begin @(posedge clk); @(negedge clk); end
    dictValid = 1'b0;
    chk1("R9 valid held", 64'(stepValid), 64'd1);
    chk1("R7 R9 data unchanged in hold", 64'(stepData == snap), 64'd1);
    chk1("R9 fetch stalled addr", 64'(fetchAddr), 64'd2);
    chk1("R9 fetchReq low while stalled", 64'(fetchReq), 64'd0);
    acceptStep();
  endtask

  task automatic testMultiWord();
    logic [STEP_W-1:0] exp;
    waitStep("R5 multi-word step presented");
    exp = sl(9, 'h0F0F);
    for (int g = 1; g <= 8; g++) exp |= sl(g, 'h100 + g);
    chkStep("R5 R4 multi-word, cleared groups, reserved nonzero ignored", exp);
    acceptStep();
  endtask

  task automatic testDuplicate();
    waitStep("R8 duplicate step presented");
    chkStep("R8 later write wins", sl(4, 'h22) | sl(13, 'h0D));
    chk1("R8 repeat flagged", 64'(stepDupErr), 64'd1);
  endtask

  task automatic testDictMerge();
    stepReady = 1'b1;
    @(posedge clk); @(negedge clk);
    stepReady = 1'b0;
    dictValid = 1'b1; dictGroup = 5'd31; dictData = 15'h01AB;
    @(posedge clk); @(negedge clk);
    dictGroup = 5'd12; dictData = 15'h4321;
    @(posedge clk); @(negedge clk);
    dictValid = 1'b0;
    chk1("R7 step after drain", 64'(stepValid), 64'd1);
    chkStep("R7 dictionary merge incl. top group",
            sl(2, 'h3) | sl(31, 'h1AB) | sl(12, 'h4321));
    chk1("R8 flag cleared for new step", 64'(stepDupErr), 64'd0);
  endtask

  task automatic testJumpMidStep();
    acceptStep();
    @(posedge clk); @(negedge clk);
    jumpValid = 1'b1; jumpAddr = 16'd20;
    @(posedge clk); @(negedge clk);
    jumpValid = 1'b0;
    chk1("R10 fetchAddr redirected", 64'(fetchAddr), 64'd20);
    chk1("R10 no step after jump", 64'(stepValid), 64'd0);
    waitStep("R10 target step presented");
    chkStep("R10 partial step discarded", sl(6, 'h66));
    chk1("R2 R9 addr after prefetch", 64'(fetchAddr), 64'd22);
  endtask

  task automatic testJumpInHold();
    jumpValid = 1'b1; jumpAddr = 16'd30;
    @(posedge clk); @(negedge clk);
    jumpValid = 1'b0;
    chk1("R10 jump drops held step", 64'(stepValid), 64'd0);
    waitStep("R10 step at second target");
    chkStep("R10 prefetched word discarded", sl(10, 'hABC) | sl(11, 'h0BB));
    acceptStep();
    waitStep("R4 empty step presented");
    chkStep("R4 marker in lane 0 gives all-zero step", '0);
  endtask

  initial begin
    for (int a = 0; a < 64; a++) mem[a] = word8(cw(9, 'h999), 0, 0, 0, 0, 0, 0, 0);
    mem[0]  = word8(cw(0, 'h1111), cw(5, 'h2AAA), cw(30, 'h7FFF), MARK,
                    cw(7, 'h1234), cw(7, 'h4321), cw(1, 'h1), cw(2, 'h2));
    mem[1]  = word8(cw(1, 'h101), cw(2, 'h102), cw(3, 'h103), cw(4, 'h104),
                    cw(5, 'h105), cw(6, 'h106), cw(7, 'h107), cw(8, 'h108));
    mem[2]  = word8(cw(9, 'h0F0F), cw(31, 'h55), MARK, 0, 0, 0, 0, 0);
    mem[3]  = word8(cw(4, 'h11), cw(4, 'h22), cw(13, 'h0D), MARK, 0, 0, 0, 0);
    mem[4]  = word8(cw(2, 'h3), MARK, 0, 0, 0, 0, 0, 0);
    mem[5]  = word8(cw(3, 'h777), cw(14, 'h1), 0, 0, 0, 0, 0, 0);
    mem[20] = word8(cw(6, 'h66), MARK, cw(3, 'h5), 0, 0, 0, 0, 0);
    mem[21] = word8(cw(15, 'h15), MARK, 0, 0, 0, 0, 0, 0);
    mem[30] = word8(cw(10, 'hABC), cw(11, 'h0BB), MARK, 0, 0, 0, 0, 0);
    mem[31] = word8(MARK, cw(1, 'h7), cw(2, 'h7), 0, 0, 0, 0, 0);

    rst = 1'b1; fetchValid = 1'b0; dictValid = 1'b0; dictGroup = '0;
    dictData = '0; jumpValid = 1'b0; jumpAddr = '0; stepReady = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    testReset();
    testLatencyAndMarker();
    testHoldAndDictIgnored();
    testMultiWord();
    testDuplicate();
    testDictMerge();
    testJumpMidStep();
    testJumpInHold();

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule